// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs one management transaction on an MDIO bus from a single 32-bit frame word. The host offers the word on a valid/ready write port. When the word is accepted, the block generates MDC by dividing the system clock and sends a 32-bit all-ones preamble. It then shifts the frame word out MSB first. Every bit sent is fed back into the LSB, so the word circulates and ends in its original position.

For read frames, the block releases the MDIO driver from the second turnaround slot to the end of the frame. It captures the 16 bits returned by the PHY into the low half of the word. The other fields come back unchanged. One word format covers both the short (Clause 22) and the extended (Clause 45) frame kinds, chosen by bit 30 of the word. At any time the host can read the live register contents on `rd_data`, including the partially rotated value while a frame is on the wire. At completion the block sets a sticky done flag and gives a one-cycle interrupt pulse.

The write port has these back-pressure rules. `wr_ready` is high only while the engine is idle. A word is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. While a frame is running, `wr_ready` stays low, and any word offered is neither accepted nor able to disturb the frame in flight.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, `rd_data` is 0, `mdc` is 0, `mdio_oe` is 0, `done` and `irq` are 0, and `wr_ready` is 1.
- R2: On an accepted write, the word is loaded into the shift register. From the next cycle, `wr_ready` is 0 and `done` is 0.
- R3: While a frame runs, MDC stays low for H system clock cycles and then high for H cycles, where H is `mdc_half`. A frame takes exactly 64 MDC periods, which is 128·H cycles from the accept edge to completion. MDC stays low while idle.
- R4: For the first 32 MDC periods, `mdio_o` is 1 and `mdio_oe` is 1.
- R5: In the following 32 periods, word bits 31 down to 0 are driven in that order. `mdio_o` changes only on the clock edge where MDC falls.
- R6: A word is a read when either of these holds: bit 30 = 1 and bits 29:28 = 2'b10, or bit 30 = 0 and bit 29 = 1. For a read, `mdio_oe` is 0 during the slots of word bits 16 down to 0. In every other slot of a running frame, `mdio_oe` is 1.
- R7: For a read, `mdio_i` sampled at the 16 MDC rising edges of the data slots becomes bits 15:0, first sample in bit 15. Bits 31:16 end unchanged. For any other frame, the final contents equal the written word, whatever `mdio_i` does.
- R8: During a non-read frame, after the n-th MDC rising edge of the frame section, `rd_data` equals the written word rotated left by n.
- R9: At completion, `done` becomes 1, `irq` is high for exactly one cycle, `wr_ready` returns to 1, and `mdio_oe` and `mdc` are 0.
- R10: Words offered while a frame is running are not accepted. They leave both the wire sequence and the final register contents unchanged.
- R11: A `mdc_half` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_half | input | DIV_W | MDC half period in clock cycles (0 acts as 1) |
| wr_valid | input | 1 | Host offers a frame word |
| wr_ready | output | 1 | Engine idle, word will be accepted |
| wr_data | input | 32 | Frame word |
| rd_data | output | 32 | Live shift register contents |
| done | output | 1 | Sticky completion flag, cleared by the next start |
| irq | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Take the accept edge as time zero. The k-th MDC rise falls at edge (2k+1)·H, the next fall at (2k+2)·H, and `done`/`irq` at edge 128·H. `wr_ready` and `done` drop one edge after acceptance. The bench counts clock edges from the accept edge and samples at the falling clock edge just after each of these points. A model PHY logs the wire at each MDC rise, and changes `mdio_i` only at MDC falls. This keeps both sides of the bus half an MDC period apart.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W   = 32;
  localparam int PRE_BITS  = 32;
  localparam int SLOTS     = PRE_BITS + FRAME_W;
  localparam int CNT_W     = $clog2(SLOTS);
  localparam int TA_SLOT   = 15;  // frame slot where the PHY takes over on reads
  localparam int DATA_SLOT = 16;  // first slot of returned data
  localparam int KIND_BIT  = 30;  // 1: short frame, 0: extended frame
  localparam int OP_HI     = 29;
  localparam int OP_LO     = 28;

  function automatic logic frame_is_read(input logic [FRAME_W-1:0] w);
    logic [1:0] op;
    op = w[OP_HI:OP_LO];
    return w[KIND_BIT] ? (op == 2'b10) : op[1];
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_eff;
  logic             wrap;
  logic             mdc_q;

  assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
  assign wrap     = en_i && (cnt_q == half_eff - DIV_W'(1));
  assign rise_o   = wrap && !mdc_q;
  assign fall_o   = wrap && mdc_q;
  assign mdc_o    = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assert_mdc_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic [FRAME_W-1:0] shreg_o,
  output logic               mdio_o,
  output logic               oe_o,
  output logic               busy_o,
  output logic               end_o
);
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   bitcnt_q;
  logic               busy_q, rd_q, o_q, oe_q;

  logic               in_frame, capture, last;
  logic [CNT_W-1:0]   slot, next_cnt, next_slot;
  logic               next_pre, next_oe;

  assign in_frame  = bitcnt_q >= CNT_W'(PRE_BITS);
  assign slot      = bitcnt_q - CNT_W'(PRE_BITS);
  assign capture   = rd_q && in_frame && (slot >= CNT_W'(DATA_SLOT));
  assign last      = bitcnt_q == CNT_W'(SLOTS - 1);
  assign next_cnt  = bitcnt_q + CNT_W'(1);
  assign next_pre  = next_cnt < CNT_W'(PRE_BITS);
  assign next_slot = next_cnt - CNT_W'(PRE_BITS);
  assign next_oe   = next_pre || !(rd_q && (next_slot >= CNT_W'(TA_SLOT)));
  assign end_o     = busy_q && fall_i && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      bitcnt_q <= '0;
      busy_q   <= 1'b0;
      rd_q     <= 1'b0;
      o_q      <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_i) begin
      shreg_q  <= word_i;
      bitcnt_q <= '0;
      busy_q   <= 1'b1;
      rd_q     <= frame_is_read(word_i);
      o_q      <= 1'b1;
      oe_q     <= 1'b1;
    end else if (busy_q) begin
      if (rise_i && in_frame) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], capture ? mdio_i : shreg_q[FRAME_W-1]};
      end
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
          o_q    <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          bitcnt_q <= next_cnt;
          o_q      <= next_pre ? 1'b1 : shreg_q[FRAME_W-1];
          oe_q     <= next_oe;
        end
      end
    end
  end

  assign shreg_o = shreg_q;
  assign mdio_o  = o_q;
  assign oe_o    = oe_q;
  assign busy_o  = busy_q;

  assert_preamble_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !in_frame) |-> (o_q && oe_q));
  assert_drive_unless_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rd_q) |-> oe_q);
  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !oe_q);
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   mdc_half,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [FRAME_W-1:0] wr_data,
  output logic [FRAME_W-1:0] rd_data,
  output logic               done,
  output logic               irq,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic busy, rise, fall, finish, start;
  logic done_q, irq_q;

  assign wr_ready = !busy;
  assign start    = wr_valid && wr_ready;

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (busy),
    .half_i (mdc_half),
    .mdc_o  (mdc),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .word_i  (wr_data),
    .rise_i  (rise),
    .fall_i  (fall),
    .mdio_i  (mdio_i),
    .shreg_o (rd_data),
    .mdio_o  (mdio_o),
    .oe_o    (mdio_oe),
    .busy_o  (busy),
    .end_o   (finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= finish;
      if (start)       done_q <= 1'b0;
      else if (finish) done_q <= 1'b1;
    end
  end

  assign done = done_q;
  assign irq  = irq_q;

  assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !wr_ready));
  assert_out_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));
  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && wr_ready));
endmodule

// File: tb/sim_mdio_mgmt_engine.sv
module sim_mdio_mgmt_engine;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [DIV_W-1:0] mdc_half = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        done, irq, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_mgmt_engine #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mdc_half(mdc_half),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_data(rd_data), .done(done), .irq(irq),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  int elapsed = 0;
  int k_rise = 0;
  logic        cur_rd = 1'b0;
  logic [15:0] phy_data = '0;
  logic        obs_o  [64];
  logic        obs_oe [64];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic garb(input int k);
    return ((k * 5) % 7) > 3;
  endfunction

  function automatic logic stim(input int k);
    if (cur_rd && k >= 48 && k < 64) return phy_data[63 - k];
    return garb(k);
  endfunction

  // model PHY: log the wire at MDC rise, change its output at MDC fall
  initial forever begin
    @(posedge mdc);
    if (k_rise < 64) begin
      obs_o[k_rise]  = mdio_o;
      obs_oe[k_rise] = mdio_oe;
    end
    k_rise++;
  end
  initial forever begin
    @(negedge mdc);
    mdio_i = stim(k_rise);
  end

  task automatic tick();
    @(posedge clk);
    elapsed++;
    @(negedge clk);
  endtask

  task automatic run_op(input logic [31:0] word, input int h, input logic [15:0] pd);
    int heff, mid, e_pre, e_bit, e_oe;
    logic [31:0] exp_fin, rot;
    heff     = (h == 0) ? 1 : h;
    cur_rd   = (word[30] ? (word[29:28] == 2'b10) : word[29]);
    phy_data = pd;
    mdc_half = DIV_W'(h);
    k_rise   = 0;
    mdio_i   = stim(0);
    @(negedge clk);
    check(wr_ready == 1'b1, "R10 ready while idle", {31'd0, wr_ready}, 32'd1);
    wr_valid = 1'b1;
    wr_data  = word;
    @(posedge clk);
    elapsed = 0;
    @(negedge clk);
    wr_valid = 1'b0;
    check(!wr_ready && !done, "R2 busy and done cleared after accept", {30'd0, wr_ready, done}, 32'd0);
    check(rd_data == word, "R2 word loaded", rd_data, word);
    if (!cur_rd) begin
      mid = (2 * (32 + 5) + 1) * heff;
      while (elapsed < mid) tick();
      rot = (word << 6) | (word >> 26);
      check(rd_data == rot, "R8 rotated contents mid-frame", rd_data, rot);
    end
    wr_valid = 1'b1;
    wr_data  = ~word;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(!wr_ready, "R10 not ready while running", {31'd0, wr_ready}, 32'd0);
    end
    wr_valid = 1'b0;
    while (!done && elapsed < 300 * heff + 20) tick();
    check(elapsed == 128 * heff, (h == 0) ? "R11 zero half acts as one" : "R3 frame length",
          32'(elapsed), 32'(128 * heff));
    check(irq == 1'b1 && wr_ready == 1'b1, "R9 irq and ready at completion", {30'd0, irq, wr_ready}, 32'd3);
    tick();
    check(irq == 1'b0 && done == 1'b1, "R9 irq single pulse, done sticky", {30'd0, irq, done}, 32'd1);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 bus parked", {30'd0, mdc, mdio_oe}, 32'd0);
    check(k_rise == 64, "R3 MDC period count", 32'(k_rise), 32'd64);
    e_pre = 0; e_bit = 0; e_oe = 0;
    for (int k = 0; k < 64; k++) begin
      logic exp_oe;
      exp_oe = (k < 32) || !(cur_rd && (k - 32) >= 15);
      if (obs_oe[k] != exp_oe) e_oe++;
      if (k < 32) begin
        if (obs_o[k] != 1'b1) e_pre++;
      end else if (exp_oe && obs_o[k] != word[63 - k]) e_bit++;
    end
    check(e_pre == 0, "R4 preamble ones", 32'(e_pre), 32'd0);
    check(e_bit == 0, "R5 frame bits MSB first", 32'(e_bit), 32'd0);
    check(e_oe == 0, "R6 output enable pattern", 32'(e_oe), 32'd0);
    exp_fin = cur_rd ? {word[31:16], pd} : word;
    check(rd_data == exp_fin, cur_rd ? "R7 read data captured" : "R7 word restored, R10 no disturbance",
          rd_data, exp_fin);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (R9 completion never seen) actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(rd_data == 32'd0, "R1 reset contents", rd_data, 32'd0);
    check(!mdc && !mdio_oe && !done && !irq && wr_ready,
          "R1 reset controls", {27'd0, mdc, mdio_oe, done, irq, wr_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int h = 0; h < 4; h++) begin
      for (int kind = 0; kind < 2; kind++) begin
        for (int op = 0; op < 4; op++) begin
          logic [31:0] w;
          logic [15:0] d;
          w = {1'b0, kind[0], op[1:0], 5'(3 + op * 7 + h), 5'(17 - op * 3 + kind), 2'b10,
               16'(16'hA5C3 ^ (op * 16'h1111) ^ (h * 16'h0F0F))};
          d = 16'(16'h3C96 + op * 16'h0123 + kind * 16'h8001 + h);
          run_op(w, h, d);
        end
      end
    end
    run_op({1'b0, 1'b1, 2'b10, 5'd21, 5'd2, 2'b10, 16'h0000}, 16, 16'hBEEF);
    run_op({1'b0, 1'b1, 2'b01, 5'd31, 5'd31, 2'b10, 16'hFFFF}, 16, 16'h0000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule